// File: doc/BRIEF.md
# Two-Port Diversity Decoder with Hard Symbol Detector

This block sits on the receive side of a downlink chain, between the resource-grid demapper and the descrambler. Each input beat carries one complex sample per antenna port, with 16-bit signed I and Q in Q15. A beat also carries a code that says whether one or two receive ports are in use, and a code that names the constellation. In single-port mode the port-0 sample is taken as the symbol itself. In two-port mode, beats arrive in even/odd pairs. The decoder keeps the even beat and, once the odd beat arrives, inverts the two-port space-frequency code. This yields two layer symbols, which leave in layer order as one stream.

Every symbol is then hard-sliced against fixed Q15 thresholds into 2, 4 or 6 bits. The bits appear on a 6-bit bus with a valid flag, ready for descrambling. No channel estimate is applied: the samples are taken as already equalised.

Top module: `rxdd_top`

## Requirements
- R1: While reset is held and after it is released, with no input beat accepted, `out_valid` is 0 and `out_bits` is 0.
- R2: The port code 01 selects single-port mode. A beat accepted in this mode yields one symbol from the port-0 sample (y0), with `out_valid` high in the cycle after the input edge.
- R3: The modulation code 00 selects QPSK. The result is `out_bits[1]` = 1 when I is negative and `out_bits[0]` = 1 when Q is negative, with bits 5..2 at zero. A value of zero counts as positive.
- R4: The modulation code 01 selects 16QAM. Bits 3 and 2 are the I and Q sign bits as in R3. Bits 1 and 0 are 1 when |I| or |Q| respectively exceeds 20725 (2/√10 in Q15). Bits 5 and 4 are zero.
- R5: The modulation code 10 selects 64QAM. Bits 5 and 4 are the I and Q signs. Bits 3 and 2 flag |I| and |Q| above 20225. For the I component, bit 1 is set by the amplitude level of |I|, where the boundaries at 10112, 20225 and 30337 split the range into levels 1, 3, 5 and 7. Level 1 sets bit 1 to 1, level 3 to 0, level 5 to 0 and level 7 to 1. Bit 0 follows the same rule for Q.
- R6: A magnitude exactly equal to a threshold is sliced to the level nearer zero.
- R7: The port code 10 selects two-port mode. From the even beat (e) and the odd beat (o), with s(v) = sat16((v·23170 + 16384) >>> 15), the decoder forms:
  - x0 = ( s(e0.I + o1.I), s(e0.Q − o1.Q) )
  - x1 = ( s(o0.I − e1.I), s(o0.Q + e1.Q) )
- R8: In two-port mode the even beat yields no output. The symbol x0 leaves in the cycle after the odd beat, and x1 leaves in the cycle after that.
- R9: A beat is dropped with no output and no change to pairing if its port code is 00 or 11, or its modulation code is 11. An even beat held waiting for its odd beat is kept across such a beat.
- R10: A single-port beat in the cycle right after an odd beat is dropped, and x1 takes that output slot. A single-port beat accepted between an even and an odd beat discards the held even beat, so the next two-port beat starts a new pair.
- R11: Whenever `out_valid` is 0, `out_bits` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| ant_sel | input | 2 | Port code: 01 single port, 10 two ports |
| mod_sel | input | 2 | Constellation: 00 QPSK, 01 16QAM, 10 64QAM |
| y0_re | input | 16 | Port-0 sample, I, signed Q15 |
| y0_im | input | 16 | Port-0 sample, Q, signed Q15 |
| y1_re | input | 16 | Port-1 sample, I, signed Q15 |
| y1_im | input | 16 | Port-1 sample, Q, signed Q15 |
| out_valid | output | 1 | Symbol bits present |
| out_bits | output | 6 | Sliced bits, unused upper bits zero |

## Verification
Single-port beats walk each constellation through all four quadrants. They also hit values one below, on and one above every threshold, plus full-scale negative values, which separates sign errors from magnitude comparisons and tie handling. Two-port pairs are driven with mixed signs and with full-scale samples, which exposes a wrong conjugate sign, a swapped layer order, a rounding offset or missing saturation. Illegal codes inserted mid-pair, a single-port beat straight after a pair and a single-port beat between the halves of a pair check that the pairing state changes only as stated.

// File: rtl/rxdd_pkg.sv
package rxdd_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SUM_W    = SAMPLE_W + 1;
  localparam int PROD_W   = 2 * SUM_W;
  localparam int FRAC_W   = SAMPLE_W - 1;
  localparam int BITS_W   = 6;

  localparam logic [1:0] ANT_ONE  = 2'b01;
  localparam logic [1:0] ANT_TWO  = 2'b10;
  localparam logic [1:0] MOD_QPSK = 2'b00;
  localparam logic [1:0] MOD_Q16  = 2'b01;
  localparam logic [1:0] MOD_Q64  = 2'b10;

  // 1/sqrt(2) and slicing thresholds in Q15
  localparam logic signed [SUM_W-1:0] K_HALF_RT2 = 17'sd23170;
  localparam logic [SUM_W-1:0] TH_Q16    = 17'd20725;
  localparam logic [SUM_W-1:0] TH_Q64_LO = 17'd10112;
  localparam logic [SUM_W-1:0] TH_Q64_MD = 17'd20225;
  localparam logic [SUM_W-1:0] TH_Q64_HI = 17'd30337;

  typedef struct packed {
    logic [SAMPLE_W-1:0] re;
    logic [SAMPLE_W-1:0] im;
  } cplx_t;

  // scale a combined sum by 1/sqrt(2), round half up, saturate
  function automatic logic [SAMPLE_W-1:0] scale_sat(input logic signed [SUM_W-1:0] s);
    logic signed [PROD_W-1:0] p;
    p = PROD_W'(s) * PROD_W'(K_HALF_RT2) + (PROD_W'(1) <<< (FRAC_W - 1));
    p = p >>> FRAC_W;
    if (p > $signed(PROD_W'(32767)))       return 16'h7FFF;
    else if (p < -$signed(PROD_W'(32768))) return 16'h8000;
    else                                   return p[SAMPLE_W-1:0];
  endfunction

  function automatic logic [SUM_W-1:0] magnitude(input logic [SAMPLE_W-1:0] v);
    return v[SAMPLE_W-1] ? (SUM_W'(0) - {1'b1, v}) : {1'b0, v};
  endfunction

  // inner bit of a 64QAM axis: levels 1,3,5,7 -> 1,0,0,1
  function automatic logic q64_inner(input logic [SUM_W-1:0] m);
    return (m > TH_Q64_MD) ? (m > TH_Q64_HI) : !(m > TH_Q64_LO);
  endfunction

  function automatic logic [BITS_W-1:0] hard_slice(input cplx_t s, input logic [1:0] md);
    logic [SUM_W-1:0] mi, mq;
    logic si, sq;
    si = s.re[SAMPLE_W-1];
    sq = s.im[SAMPLE_W-1];
    mi = magnitude(s.re);
    mq = magnitude(s.im);
    case (md)
      MOD_QPSK: return {4'b0000, si, sq};
      MOD_Q16:  return {2'b00, si, sq, mi > TH_Q16, mq > TH_Q16};
      MOD_Q64:  return {si, sq, mi > TH_Q64_MD, mq > TH_Q64_MD, q64_inner(mi), q64_inner(mq)};
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/rxdd_combine.sv
module rxdd_combine
  import rxdd_pkg::*;
(
  input  cplx_t ev_p0,
  input  cplx_t ev_p1,
  input  cplx_t od_p0,
  input  cplx_t od_p1,
  output cplx_t lay0,
  output cplx_t lay1
);
  logic signed [SUM_W-1:0] s0_re, s0_im, s1_re, s1_im;

  always_comb begin
    s0_re = SUM_W'($signed(ev_p0.re)) + SUM_W'($signed(od_p1.re));
    s0_im = SUM_W'($signed(ev_p0.im)) - SUM_W'($signed(od_p1.im));
    s1_re = SUM_W'($signed(od_p0.re)) - SUM_W'($signed(ev_p1.re));
    s1_im = SUM_W'($signed(od_p0.im)) + SUM_W'($signed(ev_p1.im));
    lay0.re = scale_sat(s0_re);
    lay0.im = scale_sat(s0_im);
    lay1.re = scale_sat(s1_re);
    lay1.im = scale_sat(s1_im);
  end
endmodule

// File: rtl/rxdd_slicer.sv
module rxdd_slicer
  import rxdd_pkg::*;
(
  input  cplx_t            sym,
  input  logic [1:0]       md,
  output logic [BITS_W-1:0] bits
);
  assign bits = hard_slice(sym, md);
endmodule

// File: rtl/rxdd_top.sv
module rxdd_top
  import rxdd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  ant_sel,
  input  logic [1:0]  mod_sel,
  input  logic [15:0] y0_re,
  input  logic [15:0] y0_im,
  input  logic [15:0] y1_re,
  input  logic [15:0] y1_im,
  output logic        out_valid,
  output logic [5:0]  out_bits
);
  cplx_t cur_p0, cur_p1, held_p0, held_p1;
  cplx_t lay [LANES];
  cplx_t lane_in [LANES];
  logic [BITS_W-1:0] lane_bits [LANES];

  logic odd_phase, pend;
  logic [BITS_W-1:0] pend_bits;

  // named events for the assertions
  logic legal, take, single_take, even_take, odd_take;

  assign cur_p0 = '{re: y0_re, im: y0_im};
  assign cur_p1 = '{re: y1_re, im: y1_im};

  assign legal       = (ant_sel == ANT_ONE || ant_sel == ANT_TWO) && mod_sel != 2'b11;
  assign take        = in_valid && legal;
  assign single_take = take && ant_sel == ANT_ONE;
  assign even_take   = take && ant_sel == ANT_TWO && !odd_phase;
  assign odd_take    = take && ant_sel == ANT_TWO && odd_phase;

  rxdd_combine u_comb (
    .ev_p0(held_p0), .ev_p1(held_p1),
    .od_p0(cur_p0),  .od_p1(cur_p1),
    .lay0(lay[0]),   .lay1(lay[1])
  );

  assign lane_in[0] = (ant_sel == ANT_ONE) ? cur_p0 : lay[0];
  for (genvar g = 1; g < LANES; g++) begin : g_lane_src
    assign lane_in[g] = lay[g];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    rxdd_slicer u_slc (.sym(lane_in[g]), .md(mod_sel), .bits(lane_bits[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_phase <= 1'b0;
      held_p0   <= '0;
      held_p1   <= '0;
      pend      <= 1'b0;
      pend_bits <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      pend      <= 1'b0;
      pend_bits <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
      if (even_take) begin
        held_p0   <= cur_p0;
        held_p1   <= cur_p1;
        odd_phase <= 1'b1;
      end else if (odd_take || single_take) begin
        odd_phase <= 1'b0;
      end
      if (pend) begin
        out_valid <= 1'b1;
        out_bits  <= pend_bits;
      end else if (single_take) begin
        out_valid <= 1'b1;
        out_bits  <= lane_bits[0];
      end else if (odd_take) begin
        out_valid <= 1'b1;
        out_bits  <= lane_bits[0];
        pend      <= 1'b1;
        pend_bits <= lane_bits[LANES-1];
      end
    end
  end

  p_single_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (single_take && !pend) |=> out_valid);
  p_pair_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    odd_take |=> (out_valid ##1 out_valid));
  p_even_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (even_take && !pend) |=> !out_valid);
  p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !pend) |=> !out_valid);
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_bits == '0);
endmodule

// File: tb/rxdd_top_test.sv
module rxdd_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] ant_sel = 2'b00, mod_sel = 2'b00;
  logic [15:0] y0_re = '0, y0_im = '0, y1_re = '0, y1_im = '0;
  logic out_valid;
  logic [5:0] out_bits;

  rxdd_top uut (.*);

  always #5 clk = ~clk;

  typedef struct { logic [5:0] bits; string tag; } exp_t;
  exp_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit running = 0;

  // bench model state
  bit m_phase = 0, m_pend = 0;
  int e0r, e0i, e1r, e1i;

  function automatic int ref_scale(int s);
    longint p;
    p = (longint'(s) * 23170 + 16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic logic [1:0] q64_axis(int v);
    int m, lvl;
    m = (v < 0) ? -v : v;
    lvl = (m <= 10112) ? 1 : (m <= 20225) ? 3 : (m <= 30337) ? 5 : 7;
    case (lvl)
      1: return 2'b01;
      3: return 2'b00;
      5: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [5:0] ref_slice(int re, int im, logic [1:0] md);
    logic si, sq;
    logic [1:0] ai, aq;
    si = re < 0; sq = im < 0;
    ai = q64_axis(re); aq = q64_axis(im);
    if (md == 2'b00) return {4'b0, si, sq};
    if (md == 2'b01) return {2'b0, si, sq, ((re < 0 ? -re : re) > 20725), ((im < 0 ? -im : im) > 20725)};
    return {si, sq, ai[1], aq[1], ai[0], aq[0]};
  endfunction

  task automatic push(logic [5:0] b, string tag);
    exp_t e;
    e.bits = b; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drive(logic [1:0] a, logic [1:0] md, int p0r, int p0i, int p1r, int p1i, string tag);
    bit was_pend;
    @(negedge clk);
    in_valid = 1'b1; ant_sel = a; mod_sel = md;
    y0_re = 16'(p0r); y0_im = 16'(p0i); y1_re = 16'(p1r); y1_im = 16'(p1i);
    was_pend = m_pend;
    m_pend = 0;
    if ((a != 2'b01 && a != 2'b10) || md == 2'b11) return;
    if (a == 2'b01) begin
      m_phase = 0;
      if (!was_pend) push(ref_slice(p0r, p0i, md), tag);
    end else if (!m_phase) begin
      e0r = p0r; e0i = p0i; e1r = p1r; e1i = p1i;
      m_phase = 1;
    end else begin
      push(ref_slice(ref_scale(e0r + p1r), ref_scale(e0i - p1i), md), tag);
      push(ref_slice(ref_scale(p0r - e1r), ref_scale(p0i + e1i), md), tag);
      m_phase = 0;
      m_pend = 1;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      m_pend = 0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        n_chk++;
        if (sbq.size() == 0) begin
          n_bad++;
          $display("FAIL R9 unexpected output: actual %b expected none", out_bits);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (out_bits !== e.bits) begin
            n_bad++;
            $display("FAIL %s bits: actual %b expected %b", e.tag, out_bits, e.bits);
          end
        end
      end else if (out_bits !== 6'b0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 idle bits: actual %b expected 000000", out_bits);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R1 during reset
    if (out_valid !== 1'b0 || out_bits !== 6'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %b/%b expected 0/000000", out_valid, out_bits);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;  // R1 after release
    if (out_valid !== 1'b0 || out_bits !== 6'b0) begin
      n_bad++;
      $display("FAIL R1 post-reset: actual %b/%b expected 0/000000", out_valid, out_bits);
    end
    running = 1;

    // R2/R3 QPSK quadrants and zero
    drive(2'b01, 2'b00,  1000,  1000, 0, 0, "R3");
    drive(2'b01, 2'b00,  1000, -1000, 0, 0, "R3");
    drive(2'b01, 2'b00, -1000,  1000, 0, 0, "R3");
    drive(2'b01, 2'b00,    -5,    -5, 7, 7, "R2");
    drive(2'b01, 2'b00,     0,     0, 0, 0, "R3");
    idle(2);
    // R4 16QAM with R6 ties
    drive(2'b01, 2'b01,  20724,  20726, 0, 0, "R4");
    drive(2'b01, 2'b01,  20725, -20725, 0, 0, "R6");
    drive(2'b01, 2'b01, -20726, -32768, 0, 0, "R4");
    drive(2'b01, 2'b01,  32767,    100, 0, 0, "R4");
    // R5 64QAM levels with R6 ties
    drive(2'b01, 2'b10,   5000,  15000, 0, 0, "R5");
    drive(2'b01, 2'b10, -25000,  31000, 0, 0, "R5");
    drive(2'b01, 2'b10,  10112,  10113, 0, 0, "R6");
    drive(2'b01, 2'b10, -20225,  20226, 0, 0, "R6");
    drive(2'b01, 2'b10,  30337, -30338, 0, 0, "R6");
    drive(2'b01, 2'b10, -32768,      0, 0, 0, "R5");
    idle(3);
    // R7/R8 two-port pairs
    drive(2'b10, 2'b00,  9000, -4000,  -3000,  2000, "R7");
    drive(2'b10, 2'b00, -6000,  1500,   8000, -7000, "R7");
    drive(2'b10, 2'b01, 14000, 12000,  -9000,  5000, "R8");
    drive(2'b10, 2'b01,  3000, -2000,  16000,  9000, "R8");
    drive(2'b10, 2'b10, 32767, 32767,  32767, 32767, "R7");
    drive(2'b10, 2'b10, 32767,-32768, -32768, 32767, "R7");
    drive(2'b10, 2'b10, -7000, 21000,  12000,-18000, "R7");
    drive(2'b10, 2'b10, 25000, -4000,   6000, 30000, "R7");
    idle(3);
    // R9 illegal codes, including mid-pair
    drive(2'b00, 2'b00, 1000, 1000, 0, 0, "R9");
    drive(2'b11, 2'b01, 1000, 1000, 0, 0, "R9");
    drive(2'b01, 2'b11, 1000, 1000, 0, 0, "R9");
    drive(2'b10, 2'b10, 11000, -3000, 4000, 9000, "R9");
    drive(2'b11, 2'b00, -1, -1, -1, -1, "R9");
    drive(2'b10, 2'b11, -1, -1, -1, -1, "R9");
    drive(2'b10, 2'b10, -2000, 15000, -8000, 2500, "R9");
    idle(3);
    // R10 single right after a pair is dropped
    drive(2'b10, 2'b00,  4000,  4000, -4000,  4000, "R10");
    drive(2'b10, 2'b00, -4000,  4000,  4000,  4000, "R10");
    drive(2'b01, 2'b00, -9000, -9000,     0,     0, "R10");
    drive(2'b01, 2'b00, -9000,  9000,     0,     0, "R10");
    idle(2);
    // R10 single between halves discards the even beat
    drive(2'b10, 2'b01, 30000, 30000, 30000, 30000, "R10");
    drive(2'b01, 2'b01, -1000, 25000,     0,     0, "R10");
    drive(2'b10, 2'b01,  8000, -8000,  1000,  1000, "R10");
    drive(2'b10, 2'b01, -3000,  6000, -5000,  2000, "R10");
    idle(6);

    running = 0;
    n_chk++;
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL R8 missing outputs: actual %0d left expected 0", sbq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule